// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block sequences an external analog-to-digital converter across a range of input channels. Software programs a 16-bit control word that sets the first and last channel, the scan mode, the conversion clock select and whether a timer underflow may start a scan. A scan begins on a software write that sets the start/busy bit, or on a timer underflow pulse when the trigger enable is set. The block then asks the converter for one conversion at a time through a start/done handshake. It places each returned sample in the result register of the channel that was converted.

The start/busy bit reads 1 while a scan is running and clears by itself when the scan ends. A one-cycle interrupt pulse marks that moment. There are four scan modes: a single channel or a channel range, each converted either once or repeatedly. A repeated scan runs until software writes the start/busy bit as 0, and then it finishes the pass it is on. The result registers can be read through a separate read port at any time.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word reads 0x0000, every result register reads 0, and neither convStart nor scanDoneIrq is asserted.
- R2: The control word reads back as last channel [15:12], first channel [11:8], busy [7], trigger enable [6], clock select [5:4], zero [3:2] and mode [1:0]. The clkSel output follows bits 5:4.
- R3: A write with bit 7 = 1 while idle starts a scan. From the next cycle busy reads 1 and convStart is high for the first channel.
- R4: Mode 01 converts every channel from first to last, in ascending order, once per start. The next request is issued only after the previous done.
- R5: In the range modes (01, 11), if first > last, only the first channel is converted.
- R6: Mode 00 converts the first channel once per start.
- R7: Modes 10 and 11 restart at the first channel after each pass. Writing bit 7 = 0 while busy ends the scan when the current pass completes.
- R8: A timerUnderflow pulse starts a scan only while idle with trigger enable = 1. With trigger enable = 0 it has no effect.
- R9: While busy, triggers and start writes are ignored. A write changes no field and can only request a stop (bit 7 = 0).
- R10: Each sample is stored in the result register indexed by the converted channel and appears on rdResult when rdChannel selects it.
- R11: Busy clears in the cycle after the last done of the scan. scanDoneIrq is high for exactly that one cycle.
- R12: convStart is a one-cycle pulse that is asserted only while busy. At most one conversion is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 16 | Control word write data |
| ctrlRdData | output | 16 | Control word read-back including busy |
| timerUnderflow | input | 1 | Timer underflow trigger pulse |
| clkSel | output | 2 | Conversion clock select to the converter |
| convStart | output | 1 | Conversion request pulse |
| convChannel | output | CH_W | Channel of the current conversion |
| convDone | input | 1 | Converter done pulse |
| convResult | input | RES_W | Converter sample, valid with convDone |
| rdChannel | input | CH_W | Result register read select |
| rdResult | output | RES_W | Selected result register |
| scanDoneIrq | output | 1 | One-cycle scan-complete pulse |

## Verification
The checker enforces on every cycle the handshake rules, which R12 and R3 state for convStart and busy. It also enforces the link between the busy fall and the interrupt pulse (R11), and the channel a request must carry in single mode and in reversed-range scans (R5, R6). Some behaviour only the bench scenarios can show: the full ascending channel order and conversion count of a range scan, and repeated passes ending only at a pass boundary after a stop write. The same holds for triggers and writes being ignored while busy, and for each sample landing in the right result register. The bench shows these by comparing against its reference model on every clock.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    MODE_ONE_SINGLE = 2'b00,
    MODE_ONE_RANGE  = 2'b01,
    MODE_RPT_SINGLE = 2'b10,
    MODE_RPT_RANGE  = 2'b11
  } scanMode_t;

  typedef struct packed {
    logic cfgWr;   // capture configuration fields
    logic chLoad;  // load channel pointer with first channel
    logic chStep;  // advance channel pointer
    logic resWr;   // store converter sample
  } dpCtl_t;
endpackage

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 10,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           strb,
  input  logic [3:0]       wrLast,
  input  logic [3:0]       wrFirst,
  input  logic             wrTrig,
  input  logic [1:0]       wrClk,
  input  logic [1:0]       wrMode,
  input  logic [RES_W-1:0] convResult,
  input  logic [CH_W-1:0]  rdChannel,
  output logic [CH_W-1:0]  cfgLast,
  output logic [CH_W-1:0]  cfgFirst,
  output logic             trigEn,
  output logic [1:0]       clkSel,
  output scanMode_t        mode,
  output logic [CH_W-1:0]  curCh,
  output logic             lastHit,
  output logic [RES_W-1:0] rdResult
);
  logic [CH_W-1:0]  endCh;
  logic [RES_W-1:0] resReg [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLast  <= '0;
      cfgFirst <= '0;
      trigEn   <= 1'b0;
      clkSel   <= 2'b00;
      mode     <= MODE_ONE_SINGLE;
    end else if (strb.cfgWr) begin
      cfgLast  <= CH_W'(wrLast);
      cfgFirst <= CH_W'(wrFirst);
      trigEn   <= wrTrig;
      clkSel   <= wrClk;
      mode     <= scanMode_t'(wrMode);
    end
  end

  // A start in the same cycle as a config write must see the new first channel
  always_ff @(posedge clk) begin
    if (!rstN)
      curCh <= '0;
    else if (strb.chLoad)
      curCh <= strb.cfgWr ? CH_W'(wrFirst) : cfgFirst;
    else if (strb.chStep)
      curCh <= curCh + 1'b1;
  end

  // Range modes stop at last unless the range is reversed; single modes stop at first
  always_comb begin
    if (mode[0] && (cfgLast > cfgFirst))
      endCh = cfgLast;
    else
      endCh = cfgFirst;
  end

  assign lastHit = (curCh == endCh);

  for (genvar g = 0; g < NUM_CH; g++) begin : gRes
    always_ff @(posedge clk) begin
      if (!rstN)
        resReg[g] <= '0;
      else if (strb.resWr && (curCh == CH_W'(g)))
        resReg[g] <= convResult;
    end
  end

  assign rdResult = resReg[rdChannel];
endmodule

// File: rtl/adc_scan_ctl.sv
module adc_scan_ctl
  import adc_scan_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   ctrlWrEn,
  input  logic   wrStartBit,
  input  logic   wrTrigBit,
  input  logic   timerUnderflow,
  input  logic   trigEn,
  input  logic   repeatMode,
  input  logic   lastHit,
  input  logic   convDone,
  output dpCtl_t strb,
  output logic   busy,
  output logic   convStart,
  output logic   scanDoneIrq
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} ctlState_t;

  ctlState_t state, stateNext;
  logic      stopReq;
  logic      idle, startNow, done, wrap, endScan;

  assign idle     = (state == ST_IDLE);
  assign startNow = idle && (ctrlWrEn ? (wrStartBit || (timerUnderflow && wrTrigBit))
                                      : (timerUnderflow && trigEn));
  assign done     = (state == ST_WAIT) && convDone;
  assign wrap     = done && lastHit && repeatMode && !stopReq;
  assign endScan  = done && lastHit && !wrap;

  always_comb begin
    strb.cfgWr  = ctrlWrEn && idle;
    strb.chLoad = startNow || wrap;
    strb.chStep = done && !lastHit;
    strb.resWr  = done;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startNow) stateNext = ST_ISSUE;
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT:  if (done) stateNext = endScan ? ST_IDLE : ST_ISSUE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      stopReq     <= 1'b0;
      scanDoneIrq <= 1'b0;
    end else begin
      state       <= stateNext;
      scanDoneIrq <= endScan;
      if (endScan)
        stopReq <= 1'b0;
      else if (ctrlWrEn && !idle && !wrStartBit)
        stopReq <= 1'b1;
    end
  end

  assign busy      = !idle;
  assign convStart = (state == ST_ISSUE);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrEn,
  input  logic [15:0]      ctrlWrData,
  output logic [15:0]      ctrlRdData,
  input  logic             timerUnderflow,
  output logic [1:0]       clkSel,
  output logic             convStart,
  output logic [CH_W-1:0]  convChannel,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  input  logic [CH_W-1:0]  rdChannel,
  output logic [RES_W-1:0] rdResult,
  output logic             scanDoneIrq
);
  dpCtl_t          strb;
  logic [CH_W-1:0] cfgLast, cfgFirst, curCh;
  logic            trigEn, lastHit, busy;
  scanMode_t       mode;
  logic            unusedBits;

  assign unusedBits = ^ctrlWrData[3:2];

  adc_scan_ctl uCtl (
    .clk            (clk),
    .rstN           (rstN),
    .ctrlWrEn       (ctrlWrEn),
    .wrStartBit     (ctrlWrData[7]),
    .wrTrigBit      (ctrlWrData[6]),
    .timerUnderflow (timerUnderflow),
    .trigEn         (trigEn),
    .repeatMode     (mode[1]),
    .lastHit        (lastHit),
    .convDone       (convDone),
    .strb           (strb),
    .busy           (busy),
    .convStart      (convStart),
    .scanDoneIrq    (scanDoneIrq)
  );

  adc_scan_dp #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrLast     (ctrlWrData[15:12]),
    .wrFirst    (ctrlWrData[11:8]),
    .wrTrig     (ctrlWrData[6]),
    .wrClk      (ctrlWrData[5:4]),
    .wrMode     (ctrlWrData[1:0]),
    .convResult (convResult),
    .rdChannel  (rdChannel),
    .cfgLast    (cfgLast),
    .cfgFirst   (cfgFirst),
    .trigEn     (trigEn),
    .clkSel     (clkSel),
    .mode       (mode),
    .curCh      (curCh),
    .lastHit    (lastHit),
    .rdResult   (rdResult)
  );

  assign convChannel = curCh;
  assign ctrlRdData  = {4'(cfgLast), 4'(cfgFirst), busy, trigEn, clkSel, 2'b00, mode};
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [15:0]     ctrlRdData,
  input logic            convStart,
  input logic [CH_W-1:0] convChannel,
  input logic            scanDoneIrq
);
  logic busyBit;
  assign busyBit = ctrlRdData[7];

  // R12
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busyBit);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyBit) |-> convStart);

  // R11
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyBit) |-> scanDoneIrq);

  // R11
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanDoneIrq |-> (!busyBit && $past(busyBit)));

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanDoneIrq |=> !scanDoneIrq);

  // R6
  single_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !ctrlRdData[0]) |-> (4'(convChannel) == ctrlRdData[11:8]));

  // R5
  reversed_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && ctrlRdData[0] && (ctrlRdData[11:8] > ctrlRdData[15:12]))
      |-> (4'(convChannel) == ctrlRdData[11:8]));
endmodule

bind adc_scan_seq adc_scan_chk #(.CH_W(CH_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlRdData  (ctrlRdData),
  .convStart   (convStart),
  .convChannel (convChannel),
  .scanDoneIrq (scanDoneIrq)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 16;
  localparam int RES_W  = 10;
  localparam int CH_W   = 4;
  localparam int LAT    = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ctrlWrEn = 1'b0;
  logic [15:0]      ctrlWrData = '0;
  logic [15:0]      ctrlRdData;
  logic             timerUnderflow = 1'b0;
  logic [1:0]       clkSel;
  logic             convStart;
  logic [CH_W-1:0]  convChannel;
  logic             convDone = 1'b0;
  logic [RES_W-1:0] convResult = '0;
  logic [CH_W-1:0]  rdChannel = '0;
  logic [RES_W-1:0] rdResult;
  logic             scanDoneIrq;

  int checks = 0;
  int errors = 0;
  int nStarts = 0;
  int stubCnt = 0;
  int stubSeq = 0;

  adc_scan_seq #(.NUM_CH(NUM_CH), .RES_W(RES_W)) uut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .timerUnderflow(timerUnderflow), .clkSel(clkSel),
    .convStart(convStart), .convChannel(convChannel), .convDone(convDone),
    .convResult(convResult), .rdChannel(rdChannel), .rdResult(rdResult),
    .scanDoneIrq(scanDoneIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int mState = 0;          // 0 idle, 1 issue, 2 wait
  int mFirst = 0, mLast = 0, mClk = 0, mMode = 0;
  bit mTrig = 0, mStop = 0, mIrq = 0;
  int mRes [NUM_CH];
  int chQ [$];

  function automatic void fillPass();
    chQ.delete();
    chQ.push_back(mFirst);
    if (mMode % 2 == 1)
      for (int c = mFirst + 1; c <= mLast; c++) chQ.push_back(c);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mFirst = 0; mLast = 0; mClk = 0; mMode = 0;
      mTrig = 0; mStop = 0; mIrq = 0; chQ.delete();
      for (int i = 0; i < NUM_CH; i++) mRes[i] = 0;
    end else begin
      bit startNow, wrStop, ended;
      startNow = 0; ended = 0;
      wrStop = ctrlWrEn && (mState != 0) && !ctrlWrData[7];
      mIrq = 0;
      if (mState == 0) begin
        if (ctrlWrEn) begin
          mLast = ctrlWrData[15:12]; mFirst = ctrlWrData[11:8];
          mTrig = ctrlWrData[6]; mClk = ctrlWrData[5:4]; mMode = ctrlWrData[1:0];
          startNow = ctrlWrData[7] || (timerUnderflow && ctrlWrData[6]);
        end else begin
          startNow = timerUnderflow && mTrig;
        end
      end
      if (mState == 1) mState = 2;
      else if (mState == 2 && convDone) begin
        mRes[chQ[0]] = convResult;
        void'(chQ.pop_front());
        if (chQ.size() == 0) begin
          if (mMode >= 2 && !mStop) begin fillPass(); mState = 1; end
          else begin mState = 0; mIrq = 1; ended = 1; end
        end else mState = 1;
      end
      if (ended) mStop = 0;
      else if (wrStop) mStop = 1;
      if (startNow) begin fillPass(); mState = 1; end
    end
  end

  // ---------------- converter stub ----------------
  always @(negedge clk) begin
    convDone <= 1'b0;
    if (stubCnt > 0) begin
      stubCnt--;
      if (stubCnt == 0) begin
        convDone <= 1'b1;
        convResult <= RES_W'(((int'(convChannel) * 37 + stubSeq * 11) | 1));
        stubSeq++;
      end
    end
    if (rstN && convStart) begin
      stubCnt = LAT;
      nStarts++;
    end
  end

  always @(posedge clk) rdChannel <= rdChannel + 1'b1;

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rstN) begin
      int expWord;
      expWord = (mLast << 12) | (mFirst << 8) | ((mState != 0) << 7) | (int'(mTrig) << 6)
              | (mClk << 4) | mMode;
      chk(ctrlRdData == 16'(expWord), "R2 R9 R11 control word", ctrlRdData, expWord);
      chk(clkSel == 2'(mClk), "R2 clkSel", clkSel, mClk);
      chk(convStart == (mState == 1), "R3 R12 convStart", convStart, mState == 1);
      if (mState == 1)
        chk(int'(convChannel) == chQ[0], "R4 R5 R6 R7 convChannel", convChannel, chQ[0]);
      chk(scanDoneIrq == mIrq, "R11 scanDoneIrq", scanDoneIrq, mIrq);
      chk(int'(rdResult) == mRes[rdChannel], "R10 rdResult", rdResult, mRes[rdChannel]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic writeCtrl(input logic [15:0] d);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = d;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic pulseTimer();
    @(negedge clk);
    timerUnderflow = 1'b1;
    @(negedge clk);
    timerUnderflow = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!ctrlRdData[7]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] word(input int last, input int first, input bit go,
                                       input bit trg, input int ck, input int md);
    return 16'((last << 12) | (first << 8) | (int'(go) << 7) | (int'(trg) << 6) | (ck << 4) | md);
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(ctrlRdData == 16'h0000, "R1 control after reset", ctrlRdData, 0);
    chk(rdResult == '0, "R1 result after reset", rdResult, 0);
    chk(!convStart && !scanDoneIrq, "R1 outputs idle", {convStart, scanDoneIrq}, 0);

    // R2 configure without start
    writeCtrl(word(5, 2, 0, 0, 2, 1));
    @(negedge clk);
    chk(ctrlRdData == 16'h5221, "R2 read-back", ctrlRdData, 16'h5221);

    // R3 R4 range scan once: channels 2..5
    nStarts = 0;
    writeCtrl(word(5, 2, 1, 0, 2, 1));
    waitIdle();
    chk(nStarts == 4, "R4 conversions in range scan", nStarts, 4);

    // R5 reversed range
    nStarts = 0;
    writeCtrl(word(3, 7, 1, 0, 1, 1));
    waitIdle();
    chk(nStarts == 1, "R5 reversed range count", nStarts, 1);

    // R6 single channel once
    nStarts = 0;
    writeCtrl(word(12, 9, 1, 0, 3, 0));
    waitIdle();
    chk(nStarts == 1, "R6 single once count", nStarts, 1);

    // R7 R9 repeated range with stop; the stop write tries to change fields
    nStarts = 0;
    writeCtrl(word(2, 0, 1, 0, 0, 3));
    repeat (20) @(negedge clk);
    writeCtrl(word(9, 5, 0, 1, 3, 1));
    waitIdle();
    chk(nStarts >= 6 && nStarts % 3 == 0, "R7 whole passes before stop", nStarts, 6);
    chk(ctrlRdData == 16'h2003, "R9 fields kept through busy write", ctrlRdData, 16'h2003);

    // R7 repeated single channel
    nStarts = 0;
    writeCtrl(word(0, 4, 1, 0, 0, 2));
    repeat (15) @(negedge clk);
    writeCtrl(word(0, 4, 0, 0, 0, 2));
    waitIdle();
    chk(nStarts >= 2, "R7 repeated single conversions", nStarts, 2);

    // R8 trigger with enable clear
    writeCtrl(word(3, 1, 0, 0, 0, 1));
    nStarts = 0;
    pulseTimer();
    repeat (3) @(negedge clk);
    chk(nStarts == 0 && !ctrlRdData[7], "R8 trigger ignored when disabled", nStarts, 0);

    // R8 R9 trigger with enable set, retrigger and start write while busy
    writeCtrl(word(3, 1, 0, 1, 0, 1));
    nStarts = 0;
    pulseTimer();
    repeat (2) @(negedge clk);
    pulseTimer();
    writeCtrl(word(3, 1, 1, 1, 0, 1));
    waitIdle();
    chk(nStarts == 3, "R8 R9 one scan per idle trigger", nStarts, 3);

    // R10 sweep all result registers via rdChannel
    repeat (2 * NUM_CH) @(negedge clk);
    chk(errors == 0, "R10 R12 cumulative comparison", errors, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule